// File: doc/BRIEF.md
# Early Byte-Lane Enable Capture for a 32-bit Bus Slave

This block generates the byte-lane enables for a 32-bit bus slave on a bus where a master may drive the four data strobes early in a full cycle, together with the address. The slave samples the strobes when the full-cycle strobe asserts. If at least one sampled strobe is active, that sampled set becomes the byte-lane enable for the whole cycle. A flag tells the rest of the slave that the cycle runs in early mode.

A master does not have to drive the strobes early. When none of the sampled strobes is active, the block falls back to the live strobes at data time. In that case it gates them with the data output enable. In both modes, a separate write-latch enable follows the live strobes during data time. Write data capture therefore does not depend on the early sampling.

The whole block runs on one clock with a synchronous active-high reset. The falling edge of the full-cycle strobe is detected against a registered copy of that strobe. Address decode and data storage belong to the surrounding slave.

Top module: `ebl_slave_lanes`

## Requirements
- R1: While `rst` is high, and at the first sample after any clock edge where it was high, `early_mode` is 0, `lane_en` is 4'b0000 and `wr_latch` is 0. Reset may be asserted in the middle of a cycle.
- R2: A falling edge of `fcs_n` is a clock edge at which `fcs_n` is 0 and was 1 at the previous edge (or reset was active at the previous edge). If at that edge at least one `ds_n` bit is 0, then after it `early_mode` is 1 and `lane_en[i]` equals the inverse of `ds_n[i]` as sampled at that edge.
- R3: Once in early mode, `lane_en` and `early_mode` keep their captured values while `fcs_n` stays 0, whatever `ds_n` and `doe` do.
- R4: If all `ds_n` bits are 1 at the falling edge, `early_mode` is 0 after it. While `fcs_n` stays 0 and `doe` is 1, `lane_en[i]` is the inverse of the live `ds_n[i]`.
- R5: In fallback mode with `doe` at 0, `lane_en` is 4'b0000.
- R6: While `fcs_n` is 1, `lane_en` is 4'b0000. The first clock edge that sees `fcs_n` at 1 clears `early_mode` and the captured set. At the edge of the falling edge itself, `lane_en` is still 4'b0000.
- R7: `wr_latch` is 1 exactly when a cycle is in progress (a falling edge has been taken and `fcs_n` is still 0), `rd_nwr` is 0, `doe` is 1 and at least one `ds_n` bit is 0. This holds in either mode.
- R8: `wr_latch` is 0 whenever `rd_nwr` is 1 (read cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcs_n | input | 1 | Full-cycle strobe, active low |
| ds_n | input | 4 | Data strobes, active low, bit i selects byte lane i |
| doe | input | 1 | Data output enable, active high |
| rd_nwr | input | 1 | 1 for read, 0 for write |
| lane_en | output | 4 | Byte-lane enables, active high |
| early_mode | output | 1 | 1 when the current cycle uses early-captured lanes |
| wr_latch | output | 1 | Write data latch enable, active high |

## Verification
A wrong captured set shows up on `lane_en` at the first sample after the falling edge. It then stays wrong for the whole early cycle, because later strobe changes no longer reach the output. A mode flag that is stuck or cleared late shows up at once. The output then follows or ignores the live strobes and `doe` in the wrong way, or keeps non-zero lanes into the next cycle's first sample. The bench runs a cycle-level reference model and compares all three outputs every cycle. Most faults are therefore reported within one or two cycles of the stimulus that exposes them.

// File: rtl/ebl_pkg.sv
package ebl_pkg;

    localparam int unsigned NUM_LANES = 4;

    typedef logic [NUM_LANES-1:0] lanes_t;

    // Per-cycle capture state: cycle in progress, early mode, captured lanes
    typedef struct packed {
        logic   in_cycle;
        logic   early;
        lanes_t held;
    } cap_state_t;

    function automatic logic any_lane(input lanes_t v);
        return |v;
    endfunction

    function automatic lanes_t to_active_high(input lanes_t v_n);
        return ~v_n;
    endfunction

endpackage

// File: rtl/ebl_edge_capture.sv
module ebl_edge_capture
    import ebl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fcs_n,
    input  lanes_t     ds_n,
    output cap_state_t st
);

    logic       fcs_prev;
    logic       fall;
    lanes_t     live;
    cap_state_t st_next;

    assign live = to_active_high(ds_n);
    assign fall = fcs_prev & ~fcs_n;

    always_comb begin
        st_next = st;
        if (fcs_n) begin
            st_next = '0;
        end else if (fall) begin
            st_next.in_cycle = 1'b1;
            st_next.early    = any_lane(live);
            st_next.held     = live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcs_prev <= 1'b1;
            st       <= '0;
        end else begin
            fcs_prev <= fcs_n;
            st       <= st_next;
        end
    end

    // R2: an early strobe at the falling edge selects early mode with that set
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (fall && (ds_n != '1)) |=> (st.early && st.in_cycle && (st.held == ~$past(ds_n))));

    // R4: no strobe at the falling edge keeps the cycle in fallback mode
    a_r4_fallback_entry: assert property (@(posedge clk) disable iff (rst)
        (fall && (ds_n == '1)) |=> (!st.early && st.in_cycle));

    // R3: captured state is frozen while the strobe stays asserted
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (st.in_cycle && !fcs_n) |=> ($stable(st.held) && $stable(st.early)));

    // R6: a negated full-cycle strobe clears everything
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        fcs_n |=> (!st.early && !st.in_cycle && (st.held == '0)));

endmodule

// File: rtl/ebl_lane_mux.sv
module ebl_lane_mux
    import ebl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cap_state_t st,
    input  logic       fcs_n,
    input  lanes_t     ds_n,
    input  logic       doe,
    output lanes_t     lane_en
);

    logic active;
    assign active = st.in_cycle & ~fcs_n;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_comb begin
            if (!active)
                lane_en[g] = 1'b0;
            else if (st.early)
                lane_en[g] = st.held[g];
            else
                lane_en[g] = doe & ~ds_n[g];
        end
    end

    // R5: fallback without data output enable drives no lanes
    a_r5_gate: assert property (@(posedge clk) disable iff (rst)
        (!st.early && !doe) |-> (lane_en == '0));

    // R6: no lanes outside an asserted full-cycle strobe
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        fcs_n |-> (lane_en == '0));

endmodule

// File: rtl/ebl_write_gate.sv
module ebl_write_gate
    import ebl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_cycle,
    input  logic   fcs_n,
    input  lanes_t ds_n,
    input  logic   doe,
    input  logic   rd_nwr,
    output logic   wr_latch
);

    assign wr_latch = in_cycle & ~fcs_n & ~rd_nwr & doe & any_lane(to_active_high(ds_n));

    // R8: reads never latch write data
    a_r8_read: assert property (@(posedge clk) disable iff (rst)
        rd_nwr |-> !wr_latch);

    // R7: latching needs the data output enable
    a_r7_needs_doe: assert property (@(posedge clk) disable iff (rst)
        !doe |-> !wr_latch);

endmodule

// File: rtl/ebl_slave_lanes.sv
module ebl_slave_lanes
    import ebl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fcs_n,
    input  logic [NUM_LANES-1:0] ds_n,
    input  logic                 doe,
    input  logic                 rd_nwr,
    output logic [NUM_LANES-1:0] lane_en,
    output logic                 early_mode,
    output logic                 wr_latch
);

    cap_state_t st;

    ebl_edge_capture i_capture (
        .clk   (clk),
        .rst   (rst),
        .fcs_n (fcs_n),
        .ds_n  (ds_n),
        .st    (st)
    );

    ebl_lane_mux i_mux (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .fcs_n   (fcs_n),
        .ds_n    (ds_n),
        .doe     (doe),
        .lane_en (lane_en)
    );

    ebl_write_gate i_wgate (
        .clk      (clk),
        .rst      (rst),
        .in_cycle (st.in_cycle),
        .fcs_n    (fcs_n),
        .ds_n     (ds_n),
        .doe      (doe),
        .rd_nwr   (rd_nwr),
        .wr_latch (wr_latch)
    );

    assign early_mode = st.early;

    // R3: in early mode the lanes follow the captured set, never the live strobes
    a_r3_early_lanes: assert property (@(posedge clk) disable iff (rst)
        (early_mode && !fcs_n) |-> (lane_en != '0));

endmodule

// File: tb/test_ebl_slave_lanes.sv
module test_ebl_slave_lanes;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fcs_n = 1'b1;
    logic [3:0] ds_n = 4'hF;
    logic       doe = 1'b0;
    logic       rd_nwr = 1'b1;
    logic [3:0] lane_en;
    logic       early_mode;
    logic       wr_latch;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic       m_prev = 1'b1;
    logic       m_in = 1'b0;
    logic       m_early = 1'b0;
    logic [3:0] m_held = 4'h0;

    always #10 clk = ~clk;

    ebl_slave_lanes i_ebl_slave_lanes (
        .clk        (clk),
        .rst        (rst),
        .fcs_n      (fcs_n),
        .ds_n       (ds_n),
        .doe        (doe),
        .rd_nwr     (rd_nwr),
        .lane_en    (lane_en),
        .early_mode (early_mode),
        .wr_latch   (wr_latch)
    );

    function automatic logic [3:0] exp_lanes();
        if (!m_in || fcs_n) return 4'h0;
        if (m_early) return m_held;
        return doe ? ~ds_n : 4'h0;
    endfunction

    function automatic logic exp_wr();
        return m_in && !fcs_n && !rd_nwr && doe && (ds_n != 4'hF);
    endfunction

    function automatic string lane_tag(input logic was_rst);
        if (was_rst) return "R1";
        if (!m_in || fcs_n) return "R6";
        if (m_early) return "R3/R2";
        return doe ? "R4" : "R5";
    endfunction

    task automatic check_outputs(input logic was_rst);
        string t;
        t = lane_tag(was_rst);
        checks++;
        if (lane_en !== exp_lanes()) begin
            errors++;
            $display("FAIL %s lane_en actual=%b expected=%b", t, lane_en, exp_lanes());
        end
        checks++;
        if (early_mode !== m_early) begin
            errors++;
            $display("FAIL %s early_mode actual=%b expected=%b", t, early_mode, m_early);
        end
        checks++;
        if (wr_latch !== exp_wr()) begin
            errors++;
            $display("FAIL %s wr_latch actual=%b expected=%b",
                     was_rst ? "R1" : (rd_nwr ? "R8" : "R7"), wr_latch, exp_wr());
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_prev = 1'b1; m_in = 1'b0; m_early = 1'b0; m_held = 4'h0;
        end else begin
            if (fcs_n) begin
                m_in = 1'b0; m_early = 1'b0; m_held = 4'h0;
            end else if (m_prev) begin
                m_in = 1'b1; m_held = ~ds_n; m_early = (ds_n != 4'hF);
            end
            m_prev = fcs_n;
        end
    endtask

    // drive at negedge, let one posedge pass, then check at the next negedge
    task automatic step(input logic r, input logic f, input logic [3:0] d,
                        input logic oe, input logic rd);
        logic was_rst;
        rst = r; fcs_n = f; ds_n = d; doe = oe; rd_nwr = rd;
        @(posedge clk);
        model_edge();
        was_rst = rst;
        @(negedge clk);
        check_outputs(was_rst);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       f;
        logic [3:0] d;
        void'($urandom(32'h1A2B3C4D));
        @(negedge clk);
        // R1: reset state
        step(1, 1, 4'hF, 0, 1);
        step(1, 0, 4'h0, 1, 0);
        // R2: early capture lanes 0 and 2 (ds_n=1010)
        step(0, 1, 4'hF, 0, 1);
        step(0, 0, 4'b1010, 0, 0);
        // R3: strobes and doe change, lanes stay 0101
        step(0, 0, 4'b0000, 1, 0);
        step(0, 0, 4'b1111, 0, 0);
        step(0, 0, 4'b0110, 1, 0);
        // R6: release clears
        step(0, 1, 4'hF, 0, 1);
        // R4/R5: fallback cycle
        step(0, 0, 4'hF, 0, 1);
        step(0, 0, 4'b0011, 0, 1);
        step(0, 0, 4'b0011, 1, 1);
        step(0, 0, 4'b1100, 1, 0);
        step(0, 0, 4'hF, 1, 0);
        // R1: reset mid-cycle
        step(0, 1, 4'hF, 0, 0);
        step(0, 0, 4'b0001, 1, 0);
        step(1, 0, 4'b0001, 1, 0);
        step(0, 0, 4'b0001, 1, 0);
        // random traffic
        f = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if (f) f = ($urandom_range(0, 9) < 6);
            else   f = ($urandom_range(0, 9) < 2);
            d = ($urandom_range(0, 9) < 4) ? 4'hF : 4'($urandom_range(0, 15));
            step(($urandom_range(0, 199) == 0), f, d,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule